// File: doc/BRIEF.md
# Timer Compare/Capture Pin Controller

This block is one timer channel built around a free-running 16-bit counter and two general registers, A and B. Each general register owns one pin and is configured by its own 4-bit mode field in an 8-bit control register. In a compare mode the register is loaded through a simple write port. When the counter reaches its value, the register's pin is driven low, driven high or inverted. The pin starts at a chosen level as soon as the mode is written.

In a capture mode the register stops accepting writes from the port. Instead it copies the counter when its pin shows a selected edge, or when it sees a one-cycle event pulse from a neighbouring channel. The pin input passes through a two-stage synchronizer before edge detection. The counter advances only in cycles where `cnt_en` is high. A compare match is judged only in those cycles.

Top module: `tpc_timer_pins`

## Requirements
- R1: After reset the control register reads 0x00, the counter and both general registers are 0, and both pins have `pin_out` = 0 and `pin_oe` = 0.
- R2: A control write stores `ctl_wdata` on that clock edge, and `ctl_rdata` returns it. Bits 3:0 are the register-A field, which drives pin 0. Bits 7:4 are the register-B field, which drives pin 1.
- R3: The counter adds one on each clock edge at which `cnt_en` is 1, holds otherwise, and wraps from 0xFFFF to 0x0000.
- R4: For the compare codes 0001, 0010, 0011, 0101, 0110 and 0111, the clock edge after any control write sets `pin_oe` to 1. On that same edge `pin_out` takes field bit 2 as its starting level.
- R5: In a compare mode a match is a cycle with `cnt_en` = 1 and the counter equal to the general register. On that edge the pin takes the action given by field bits 1:0: 01 drives 0, 10 drives 1, and 11 inverts the pin.
- R6: Codes 0000 and 0100, and every capture code (bit 3 = 1), give `pin_oe` = 0 from the clock edge after the control write. Under these codes `pin_out` holds its value and a match has no effect on it.
- R7: Code 1000 captures on a rising pin edge and code 1001 captures on a falling pin edge. The edge of the opposite direction is ignored. After a pin change, the first two clock edges leave the register unchanged. The third clock edge loads the counter value that was present after the second edge.
- R8: Codes 1010 and 1011 capture on both pin edges, with the same latency as R7.
- R9: Codes 11xx ignore the pin. Register A captures on an `ext_a_evt` pulse and register B captures on an `ext_c_evt` pulse. The capture takes place at the clock edge that samples the pulse and stores the counter value of that cycle.
- R10: In a compare mode, `gr_we` loads `gr_wdata` into the selected general register on that edge. In a capture mode the write is ignored.
- R11: When a starting-level load (R4) and a match (R5) fall on the same edge, the starting level wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register contents |
| gr_we | input | 2 | General register write strobes (bit 0 = A, bit 1 = B) |
| gr_wdata | input | 16 | General register write data |
| cnt_en | input | 1 | Counter increment enable |
| cnt_q | output | 16 | Counter value |
| gr_a_q | output | 16 | General register A |
| gr_b_q | output | 16 | General register B |
| pin_in | input | 2 | Pin input levels (bit 0 = A pin, bit 1 = B pin) |
| ext_a_evt | input | 1 | Neighbour channel A-register event pulse |
| ext_c_evt | input | 1 | Neighbour channel C-register event pulse |
| pin_out | output | 2 | Pin output levels |
| pin_oe | output | 2 | Pin output enables |

## Verification
A control write can make the starting-level load land on the same edge as a compare match. The bench provokes this by loading register A with the present counter value while the counter is held. It then writes the control register and raises `cnt_en` in the very next cycle. The chosen code drives the pin high on a match but starts it low, so a pin that reads 0 after that edge shows that the starting level won. A pin that reads 1 shows that the match action took over.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

  localparam int FIELD_W = 4;

  // decoded view of one 4-bit mode field
  typedef struct packed {
    logic       cap;       // capture mode
    logic       out_en;    // compare mode with pin driven
    logic       init_lvl;  // starting pin level
    logic [1:0] act;       // match action: 1 low, 2 high, 3 invert
    logic       on_rise;
    logic       on_fall;
    logic       on_ext;
  } iocfg_t;

  function automatic iocfg_t decode_field(input logic [FIELD_W-1:0] f);
    iocfg_t c;
    c = '0;
    if (!f[3]) begin
      c.out_en   = |f[1:0];
      c.init_lvl = f[2];
      c.act      = f[1:0];
    end else begin
      c.cap    = 1'b1;
      c.on_ext = f[2];
      if (!f[2]) begin
        c.on_rise = f[1] | ~f[0];
        c.on_fall = f[1] | f[0];
      end
    end
    return c;
  endfunction

  function automatic logic match_level(input logic [1:0] act, input logic cur);
    logic r;
    case (act)
      2'b01:   r = 1'b0;
      2'b10:   r = 1'b1;
      2'b11:   r = ~cur;
      default: r = cur;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tpc_counter.sv
module tpc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  output logic [CNT_W-1:0] cnt_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_q + 1'b1;
  end

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(cnt_q));

endmodule

// File: rtl/tpc_edge_sync.sv
module tpc_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  output logic rise,
  output logic fall
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_in};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;
  assign fall = ~sync_q[SYNC_STAGES-1] & prev_q;

endmodule

// File: rtl/tpc_gr_unit.sv
module tpc_gr_unit
  import tpc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FIELD_W-1:0] field,
  input  logic               ctl_wr,
  input  logic               gr_we,
  input  logic [CNT_W-1:0]   gr_wdata,
  input  logic               cnt_en,
  input  logic [CNT_W-1:0]   cnt_q,
  input  logic               pin_in,
  input  logic               ext_evt,
  output logic [CNT_W-1:0]   gr_q,
  output logic               pin_out,
  output logic               pin_oe
);

  iocfg_t cfg;
  logic   init_pend;
  logic   pin_rise, pin_fall;
  logic   match_evt;
  logic   cap_evt;

  assign cfg = decode_field(field);

  tpc_edge_sync #(.SYNC_STAGES(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_in (pin_in),
    .rise   (pin_rise),
    .fall   (pin_fall)
  );

  assign match_evt = cnt_en & ~cfg.cap & (cnt_q == gr_q);
  assign cap_evt   = cfg.cap & (cfg.on_ext ? ext_evt
                                           : ((cfg.on_rise & pin_rise) | (cfg.on_fall & pin_fall)));

  always_ff @(posedge clk) begin
    if (!rst_n) init_pend <= 1'b0;
    else        init_pend <= ctl_wr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_out <= 1'b0;
      pin_oe  <= 1'b0;
    end else if (init_pend) begin
      pin_oe <= cfg.out_en;
      if (cfg.out_en) pin_out <= cfg.init_lvl;
    end else if (match_evt && cfg.out_en) begin
      pin_out <= match_level(cfg.act, pin_out);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 gr_q <= '0;
    else if (cap_evt)           gr_q <= cnt_q;
    else if (gr_we && !cfg.cap) gr_q <= gr_wdata;
  end

  assert_init_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (init_pend && cfg.out_en) |=> (pin_oe && (pin_out == $past(cfg.init_lvl))));

  assert_init_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (init_pend && match_evt && cfg.out_en && cfg.act == 2'b10) |=> (pin_out == $past(cfg.init_lvl)));

  assert_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && !init_pend && cfg.out_en && cfg.act == 2'b11) |=> (pin_out != $past(pin_out)));

  assert_oe_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_pend && !cfg.out_en) |-> !pin_oe);

  assert_cap_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (gr_q == $past(cnt_q)));

  assert_cap_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.cap && !cap_evt) |=> $stable(gr_q));

endmodule

// File: rtl/tpc_timer_pins.sv
module tpc_timer_pins
  import tpc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctl_we,
  input  logic [2*FIELD_W-1:0] ctl_wdata,
  output logic [2*FIELD_W-1:0] ctl_rdata,
  input  logic [1:0]           gr_we,
  input  logic [CNT_W-1:0]     gr_wdata,
  input  logic                 cnt_en,
  output logic [CNT_W-1:0]     cnt_q,
  output logic [CNT_W-1:0]     gr_a_q,
  output logic [CNT_W-1:0]     gr_b_q,
  input  logic [1:0]           pin_in,
  input  logic                 ext_a_evt,
  input  logic                 ext_c_evt,
  output logic [1:0]           pin_out,
  output logic [1:0]           pin_oe
);

  localparam int NUM_GR = 2;

  logic [2*FIELD_W-1:0] ctl_q;
  logic [NUM_GR-1:0]    ext_vec;
  logic [CNT_W-1:0]     gr_arr [NUM_GR];

  always_ff @(posedge clk) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_we) ctl_q <= ctl_wdata;
  end

  assign ctl_rdata = ctl_q;
  assign ext_vec   = {ext_c_evt, ext_a_evt};

  tpc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt_en (cnt_en),
    .cnt_q  (cnt_q)
  );

  for (genvar g = 0; g < NUM_GR; g++) begin : g_gr
    tpc_gr_unit #(.CNT_W(CNT_W)) u_gr (
      .clk      (clk),
      .rst_n    (rst_n),
      .field    (ctl_q[g*FIELD_W +: FIELD_W]),
      .ctl_wr   (ctl_we),
      .gr_we    (gr_we[g]),
      .gr_wdata (gr_wdata),
      .cnt_en   (cnt_en),
      .cnt_q    (cnt_q),
      .pin_in   (pin_in[g]),
      .ext_evt  (ext_vec[g]),
      .gr_q     (gr_arr[g]),
      .pin_out  (pin_out[g]),
      .pin_oe   (pin_oe[g])
    );
  end

  assign gr_a_q = gr_arr[0];
  assign gr_b_q = gr_arr[1];

endmodule

// File: tb/tpc_timer_pins_tb.sv
module tpc_timer_pins_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  // code, expected oe, expected starting level, expected level after match
  localparam logic [6:0] CMP_VEC [8] = '{
    {4'b0001, 1'b1, 1'b0, 1'b0},
    {4'b0010, 1'b1, 1'b0, 1'b1},
    {4'b0011, 1'b1, 1'b0, 1'b1},
    {4'b0101, 1'b1, 1'b1, 1'b0},
    {4'b0110, 1'b1, 1'b1, 1'b1},
    {4'b0111, 1'b1, 1'b1, 1'b0},
    {4'b0000, 1'b0, 1'b0, 1'b0},
    {4'b0100, 1'b0, 1'b0, 1'b0}
  };

  logic        clk = 0;
  logic        rst_n = 0;
  logic        ctl_we = 0;
  logic [7:0]  ctl_wdata = 0;
  logic [7:0]  ctl_rdata;
  logic [1:0]  gr_we = 0;
  logic [15:0] gr_wdata = 0;
  logic        cnt_en = 0;
  logic [15:0] cnt_q, gr_a_q, gr_b_q;
  logic [1:0]  pin_in = 0;
  logic        ext_a_evt = 0, ext_c_evt = 0;
  logic [1:0]  pin_out, pin_oe;

  int          total = 0;
  int          bad = 0;
  int          cycles = 0;
  logic [15:0] cnt_m = 0;
  logic [15:0] c0, old_a, old_b;

  tpc_timer_pins u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .gr_we(gr_we), .gr_wdata(gr_wdata), .cnt_en(cnt_en),
    .cnt_q(cnt_q), .gr_a_q(gr_a_q), .gr_b_q(gr_b_q), .pin_in(pin_in),
    .ext_a_evt(ext_a_evt), .ext_c_evt(ext_c_evt), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WATCHDOG) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=done", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk);
    if (cnt_en && rst_n) cnt_m = cnt_m + 1'b1;
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    ctl_wdata = v; ctl_we = 1; step(); ctl_we = 0; step();
  endtask

  function automatic logic [15:0] gr_of(input int ch);
    return (ch == 0) ? gr_a_q : gr_b_q;
  endfunction

  initial begin
    @(negedge clk); step(); step();
    rst_n = 1;
    // R1 reset state
    chk("R1 ctl", ctl_rdata, 8'h00);
    chk("R1 cnt", cnt_q, 16'h0);
    chk("R1 gr_a", gr_a_q, 16'h0);
    chk("R1 gr_b", gr_b_q, 16'h0);
    chk("R1 pin_out", pin_out, 2'b00);
    chk("R1 pin_oe", pin_oe, 2'b00);

    // R2 control readback
    ctl_wdata = 8'h5A; ctl_we = 1; step(); ctl_we = 0;
    chk("R2 readback", ctl_rdata, 8'h5A);
    step();
    wr_ctl(8'h00);

    // R3 counting and hold
    cnt_en = 1; repeat (3) step(); cnt_en = 0;
    chk("R3 count", cnt_q, cnt_m);
    step();
    chk("R3 hold", cnt_q, cnt_m);

    // table walk: compare codes on both registers (R4 R5 R6 R10)
    for (int ch = 0; ch < 2; ch++) begin
      for (int v = 0; v < 8; v++) begin
        logic [3:0] code;
        code = CMP_VEC[v][6:3];
        ctl_wdata = (ch == 0) ? {4'h0, code} : {code, 4'h0};
        ctl_we = 1; step(); ctl_we = 0; step();
        chk($sformatf("R4 start level ch%0d code%0b", ch, code), pin_out[ch], CMP_VEC[v][1]);
        chk($sformatf("R6 oe ch%0d code%0b", ch, code), pin_oe[ch], CMP_VEC[v][2]);
        gr_wdata = cnt_m; gr_we[ch] = 1; step(); gr_we = 0;
        chk($sformatf("R10 compare write ch%0d", ch), gr_of(ch), cnt_m);
        cnt_en = 1; step(); cnt_en = 0;
        chk($sformatf("R5 match ch%0d code%0b", ch, code), pin_out[ch], CMP_VEC[v][0]);
      end
    end

    // R7 rising capture on A, with latency
    wr_ctl(8'h08);
    chk("R6 oe off in capture", pin_oe[0], 1'b0);
    old_a = gr_a_q;
    cnt_en = 1;
    pin_in[0] = 1; c0 = cnt_m;
    step(); step();
    chk("R7 latency", gr_a_q, old_a);
    step();
    chk("R7 rising capture", gr_a_q, c0 + 16'd2);
    old_a = gr_a_q;
    pin_in[0] = 0; repeat (4) step();
    chk("R7 falling ignored under 1000", gr_a_q, old_a);

    // R7 falling capture
    wr_ctl(8'h09);
    old_a = gr_a_q;
    pin_in[0] = 1; repeat (4) step();
    chk("R7 rising ignored under 1001", gr_a_q, old_a);
    pin_in[0] = 0; c0 = cnt_m; repeat (3) step();
    chk("R7 falling capture", gr_a_q, c0 + 16'd2);

    // R8 both edges on B
    wr_ctl(8'hA0);
    pin_in[1] = 1; c0 = cnt_m; repeat (3) step();
    chk("R8 both rise", gr_b_q, c0 + 16'd2);
    pin_in[1] = 0; c0 = cnt_m; repeat (3) step();
    chk("R8 both fall", gr_b_q, c0 + 16'd2);
    // R10 write ignored in capture mode
    cnt_en = 0;
    old_b = gr_b_q;
    gr_wdata = 16'h1234; gr_we = 2'b10; step(); gr_we = 0;
    chk("R10 capture write ignored", gr_b_q, old_b);
    cnt_en = 1;
    wr_ctl(8'hB0);
    pin_in[1] = 1; c0 = cnt_m; repeat (3) step();
    chk("R8 code 1011 rise", gr_b_q, c0 + 16'd2);

    // R9 external events
    wr_ctl(8'hCC);
    old_a = gr_a_q; old_b = gr_b_q;
    pin_in = 2'b00; repeat (4) step();
    chk("R9 pin ignored", gr_b_q, old_b);
    c0 = cnt_m; ext_a_evt = 1; step(); ext_a_evt = 0;
    chk("R9 ext A capture", gr_a_q, c0);
    chk("R9 B untouched by A event", gr_b_q, old_b);
    old_a = gr_a_q;
    step();
    c0 = cnt_m; ext_c_evt = 1; step(); ext_c_evt = 0;
    chk("R9 ext C capture", gr_b_q, c0);
    chk("R9 A untouched by C event", gr_a_q, old_a);
    cnt_en = 0;

    // R11 starting level and match on the same edge
    wr_ctl(8'h07);
    chk("R4 start high", pin_out[0], 1'b1);
    gr_wdata = cnt_m; gr_we = 2'b01; step(); gr_we = 0;
    ctl_wdata = 8'h02; ctl_we = 1; step(); ctl_we = 0;
    cnt_en = 1; step(); cnt_en = 0;
    chk("R11 start level wins", pin_out[0], 1'b0);

    // R3 wrap
    c0 = cnt_q;
    cnt_en = 1; repeat (65536) step(); cnt_en = 0;
    chk("R3 wrap", cnt_q, c0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule